// File: doc/BRIEF.md
# Disk Controller Power-Down Manager

This block governs the low-power state of a floppy-style disk controller core. It watches the host register bus and the core's idle indicators. It holds the core in one of three states: running, powered down automatically after an idle interval, or powered down on command. Two sources can request power-down. A command written to the rate register outranks the idle timer. When the commanded state is left, the idle timer takes effect again.

Whether an access wakes the core depends on which register is touched and in which direction. Some accesses request a full core reset. Some resume the core with its state intact. All other accesses are served while the core stays powered down. While powered down, the drive-side pins are disabled and the host side stays live.

Top module: `fdc_pwr_mgr`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the following cycle shows `pwr_down`=0, `pd_cause`=2'b00, `drive_pins_en`=1 and `core_reset`=1.
- R2: Suppose all motors are off, no command is busy and the FIFO is empty for `IDLE_CYCLES` consecutive edges after the last reload. The block then sets `pwr_down`=1 with `pd_cause`=2'b01 (automatic).
- R3: A motor running, a command in progress or a non-empty FIFO clears automatic power-down and reloads the idle timer to the full interval.
- R4: A write to address 4 with bit 6 set and bit 7 clear enters commanded power-down on the next cycle with `pd_cause`=2'b10. While the command holds, the cause stays 2'b10 even after the idle timer expires.
- R5: Either write requests a soft reset: address 2 with bit 2 set, or address 4 with bit 7 set. A soft reset gives a one-cycle `core_reset` pulse, clears both power-down sources and the command bit, and gives no `wake_pulse`.
- R6: A write to address 2 with any of bits 7:4 set wakes a powered-down core, with `wake_pulse` high for one cycle. A read of address 2, or a write there with bits 7:4 and bit 2 clear, does not wake it.
- R7: A read of address 4 wakes the core. So does a read or a write of address 5, and this holds from commanded power-down as well.
- R8: After any wake or soft reset, the idle timer restarts at the full interval. Automatic power-down is active again after leaving commanded power-down.
- R9: While powered down, accesses to any other address leave `pwr_down` at 1. This includes a write to address 4 with bits 7:6 clear.
- R10: `drive_pins_en` equals the inverse of `pwr_down` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | ADDR_W | Host register address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Host write data |
| motor_active | input | 1 | Any drive motor running |
| cmd_busy | input | 1 | Command engine busy |
| fifo_empty | input | 1 | Data FIFO holds no bytes |
| pwr_down | output | 1 | Core is powered down |
| pd_cause | output | 2 | 00 running, 01 automatic, 10 commanded |
| drive_pins_en | output | 1 | Enable for drive-side pins |
| wake_pulse | output | 1 | One-cycle resume request after a register wake |
| core_reset | output | 1 | Full reset request to the core |

## Verification
The bench writes address 2 with the motor bits clear and reads it while the core is down. A decoder that ignored the direction or the motor field would wake the core there. The bench lets the idle timer run out during commanded power-down, so a design that let the automatic source override the command would report cause 01. After each wake it checks that power-down does not return before a full interval. It also checks that it does return after the interval, which catches a timer that is not reloaded or that stays disarmed after a commanded wake. Soft resets through both registers must pulse `core_reset` without `wake_pulse`.

// File: rtl/fdc_pwr_pkg.sv
package fdc_pwr_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // register addresses seen on the host bus
  localparam logic [ADDR_W-1:0] A_DRVCTL    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT_RATE = 3'd4;
  localparam logic [ADDR_W-1:0] A_FIFO      = 3'd5;

  // field positions
  localparam int DRV_SRST_BIT  = 2;
  localparam int DRV_MOTOR_LSB = 4;
  localparam int NUM_MOTORS    = 4;
  localparam int RATE_PD_BIT   = 6;
  localparam int RATE_SRST_BIT = 7;

  typedef enum logic [1:0] {
    PD_NONE = 2'b00,
    PD_AUTO = 2'b01,
    PD_CMD  = 2'b10
  } pd_cause_e;

  typedef struct packed {
    logic soft_rst;
    logic reg_wake;
    logic cmd_pd_req;
  } bus_evt_t;

endpackage

// File: rtl/fdc_pwr_decode.sv
module fdc_pwr_decode
  import fdc_pwr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output bus_evt_t      evt
);
  localparam int MOTOR_MSB = DRV_MOTOR_LSB + NUM_MOTORS - 1;

  logic hit_drv, hit_sr, hit_fifo;
  logic motor_set;

  always_comb begin
    hit_drv   = (addr == A_DRVCTL);
    hit_sr    = (addr == A_STAT_RATE);
    hit_fifo  = (addr == A_FIFO);
    motor_set = |wdata[MOTOR_MSB:DRV_MOTOR_LSB];

    evt.soft_rst   = wr & ((hit_drv & wdata[DRV_SRST_BIT]) |
                           (hit_sr  & wdata[RATE_SRST_BIT]));
    evt.reg_wake   = (wr & hit_drv & motor_set) |
                     (rd & hit_sr) |
                     ((rd | wr) & hit_fifo);
    evt.cmd_pd_req = wr & hit_sr & wdata[RATE_PD_BIT] & ~wdata[RATE_SRST_BIT];
  end
endmodule

// File: rtl/fdc_pwr_idle_timer.sv
module fdc_pwr_idle_timer #(
  parameter int IDLE_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic idle,
  output logic expired
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || reload || !idle)
      cnt_q <= LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = idle && (cnt_q == '0);
endmodule

// File: rtl/fdc_pwr_ctrl.sv
module fdc_pwr_ctrl
  import fdc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_evt_t   evt,
  input  logic       idle,
  input  logic       expired,
  output logic       pwr_down,
  output logic [1:0] pd_cause,
  output logic       drive_pins_en,
  output logic       wake_pulse,
  output logic       core_reset
);
  logic      cmd_pd_q, auto_pd_q;
  logic      cmd_pd_d, auto_pd_d;
  logic      leave;
  pd_cause_e cause_d;

  always_comb begin
    leave = evt.soft_rst | evt.reg_wake;

    cmd_pd_d = cmd_pd_q;
    if (leave)               cmd_pd_d = 1'b0;
    else if (evt.cmd_pd_req) cmd_pd_d = 1'b1;

    auto_pd_d = auto_pd_q;
    if (leave || !idle)  auto_pd_d = 1'b0;
    else if (expired)    auto_pd_d = 1'b1;

    if (cmd_pd_d)       cause_d = PD_CMD;
    else if (auto_pd_d) cause_d = PD_AUTO;
    else                cause_d = PD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pd_q      <= 1'b0;
      auto_pd_q     <= 1'b0;
      pwr_down      <= 1'b0;
      pd_cause      <= PD_NONE;
      drive_pins_en <= 1'b1;
      wake_pulse    <= 1'b0;
      core_reset    <= 1'b1;
    end else begin
      cmd_pd_q      <= cmd_pd_d;
      auto_pd_q     <= auto_pd_d;
      pwr_down      <= cmd_pd_d | auto_pd_d;
      pd_cause      <= cause_d;
      drive_pins_en <= ~(cmd_pd_d | auto_pd_d);
      wake_pulse    <= evt.reg_wake & ~evt.soft_rst & (cmd_pd_q | auto_pd_q);
      core_reset    <= evt.soft_rst;
    end
  end
endmodule

// File: rtl/fdc_pwr_mgr.sv
module fdc_pwr_mgr
  import fdc_pwr_pkg::*;
#(
  parameter int IDLE_CYCLES = 2_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              motor_active,
  input  logic              cmd_busy,
  input  logic              fifo_empty,
  output logic              pwr_down,
  output logic [1:0]        pd_cause,
  output logic              drive_pins_en,
  output logic              wake_pulse,
  output logic              core_reset
);
  bus_evt_t evt;
  logic     idle, expired, reload;

  assign idle   = ~motor_active & ~cmd_busy & fifo_empty;
  assign reload = evt.soft_rst | evt.reg_wake;

  fdc_pwr_decode #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .wdata(bus_wdata),
    .evt  (evt)
  );

  fdc_pwr_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .reload (reload),
    .idle   (idle),
    .expired(expired)
  );

  fdc_pwr_ctrl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .idle         (idle),
    .expired      (expired),
    .pwr_down     (pwr_down),
    .pd_cause     (pd_cause),
    .drive_pins_en(drive_pins_en),
    .wake_pulse   (wake_pulse),
    .core_reset   (core_reset)
  );
endmodule

// File: rtl/fdc_pwr_mgr_chk.sv
module fdc_pwr_mgr_chk
  import fdc_pwr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              motor_active,
  input logic              cmd_busy,
  input logic              fifo_empty,
  input logic              pwr_down,
  input logic [1:0]        pd_cause,
  input logic              drive_pins_en,
  input logic              wake_pulse,
  input logic              core_reset
);
  logic quiet;
  assign quiet = ~motor_active & ~cmd_busy & fifo_empty;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!pwr_down && core_reset && pd_cause == 2'b00));

  p_cmd_enter_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STAT_RATE && bus_wdata[7:6] == 2'b01) |=> (pwr_down && pd_cause == 2'b10));

  p_soft_reset_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STAT_RATE && bus_wdata[7]) |=> (core_reset && !wake_pulse && !pwr_down));

  p_motor_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && bus_wr && bus_addr == A_DRVCTL && bus_wdata[7:4] != 4'h0) |=> (wake_pulse && !pwr_down));

  p_data_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && (bus_rd || bus_wr) && bus_addr == A_FIFO) |=> (wake_pulse && !pwr_down));

  p_stay_down_r9: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && quiet && bus_rd && bus_addr != A_STAT_RATE && bus_addr != A_FIFO) |=> pwr_down);

  p_wake_is_up_r6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (!pwr_down && $past(pwr_down)));

  p_pins_follow_r10: assert property (@(posedge clk) disable iff (rst)
    drive_pins_en == !pwr_down);

  p_cause_match_r2: assert property (@(posedge clk) disable iff (rst)
    pwr_down == (pd_cause != 2'b00));
endmodule

bind fdc_pwr_mgr fdc_pwr_mgr_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .motor_active(motor_active), .cmd_busy(cmd_busy),
  .fifo_empty(fifo_empty), .pwr_down(pwr_down), .pd_cause(pd_cause),
  .drive_pins_en(drive_pins_en), .wake_pulse(wake_pulse), .core_reset(core_reset)
);

// File: tb/fdc_pwr_mgr_tb.sv
`timescale 1ns/1ps
module fdc_pwr_mgr_tb;
  localparam int IDLE = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       motor_active = 1'b0, cmd_busy = 1'b0, fifo_empty = 1'b1;
  logic       pwr_down, drive_pins_en, wake_pulse, core_reset;
  logic [1:0] pd_cause;

  int checks = 0, failures = 0;
  logic seen_wake, seen_rst;

  always #2.5 clk = ~clk;

  fdc_pwr_mgr #(.IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .motor_active(motor_active), .cmd_busy(cmd_busy),
    .fifo_empty(fifo_empty), .pwr_down(pwr_down), .pd_cause(pd_cause),
    .drive_pins_en(drive_pins_en), .wake_pulse(wake_pulse), .core_reset(core_reset)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input int pd, input int cause);
    check(req, pwr_down, pd);
    check(req, pd_cause, cause);
    check("R10", drive_pins_en, pd == 0 ? 1 : 0);
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic acc(input logic [2:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    @(negedge clk);
    seen_wake = wake_pulse; seen_rst = core_reset;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", core_reset, 1);
    check_state("R1", 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_auto();
    idle_wait(IDLE - 4);
    check_state("R2 early", 0, 0);
    idle_wait(8);
    check_state("R2", 1, 1);
  endtask

  task automatic t_ignored();
    acc(3'd2, 1'b0, 1'b1, 8'h00);
    check("R6 no-motor write", seen_wake, 0);
    check_state("R6 no-motor write", 1, 1);
    acc(3'd2, 1'b1, 1'b0, 8'h00);
    check("R6 read", seen_wake, 0);
    check_state("R6 read", 1, 1);
    acc(3'd4, 1'b0, 1'b1, 8'h02);
    check_state("R9 rate write", 1, 1);
    acc(3'd0, 1'b1, 1'b0, 8'h00);
    acc(3'd7, 1'b0, 1'b1, 8'hFF);
    check_state("R9 other", 1, 1);
  endtask

  task automatic t_status_wake();
    acc(3'd4, 1'b1, 1'b0, 8'h00);
    check("R7 status wake", seen_wake, 1);
    check("R7 no reset", seen_rst, 0);
    check_state("R7", 0, 0);
    idle_wait(IDLE - 4);
    check_state("R8 restart", 0, 0);
    idle_wait(8);
    check_state("R8 redown", 1, 1);
  endtask

  task automatic t_motor_wake();
    acc(3'd2, 1'b0, 1'b1, 8'h20);
    check("R6 motor wake", seen_wake, 1);
    check_state("R6 motor wake", 0, 0);
  endtask

  task automatic t_cmd();
    acc(3'd4, 1'b0, 1'b1, 8'h40);
    check_state("R4 enter", 1, 2);
    idle_wait(IDLE + 10);
    check_state("R4 priority", 1, 2);
    acc(3'd5, 1'b0, 1'b1, 8'h11);
    check("R7 data wake cmd", seen_wake, 1);
    check_state("R7 data wake cmd", 0, 0);
    idle_wait(IDLE + 6);
    check_state("R8 auto rearm", 1, 1);
    acc(3'd5, 1'b1, 1'b0, 8'h00);
    check("R7 data read", seen_wake, 1);
  endtask

  task automatic t_soft_reset();
    idle_wait(IDLE + 6);
    check_state("R5 pre", 1, 1);
    acc(3'd4, 1'b0, 1'b1, 8'h80);
    check("R5 rate reset", seen_rst, 1);
    check("R5 no wake", seen_wake, 0);
    check_state("R5 rate", 0, 0);
    @(negedge clk);
    check("R5 pulse", core_reset, 0);
    acc(3'd4, 1'b0, 1'b1, 8'h40);
    acc(3'd2, 1'b0, 1'b1, 8'h04);
    check("R5 drv reset", seen_rst, 1);
    check_state("R5 drv", 0, 0);
    idle_wait(IDLE - 4);
    check_state("R8 after reset", 0, 0);
  endtask

  task automatic t_not_idle();
    motor_active = 1'b1;
    idle_wait(IDLE + 10);
    check_state("R3 motor", 0, 0);
    motor_active = 1'b0;
    idle_wait(IDLE - 4);
    check_state("R3 reload", 0, 0);
    idle_wait(8);
    check_state("R3 down", 1, 1);
    fifo_empty = 1'b0;
    idle_wait(2);
    check_state("R3 fifo", 0, 0);
    fifo_empty = 1'b1;
  endtask

  initial begin
    rst = 1'b1;
    idle_wait(3);
    check("R1", core_reset, 1);
    check_state("R1", 0, 0);
    rst = 1'b0;
    t_auto();
    t_ignored();
    t_status_wake();
    t_motor_wake();
    t_cmd();
    t_soft_reset();
    t_not_idle();
    acc(3'd4, 1'b0, 1'b1, 8'h40);
    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule